// File: doc/BRIEF.md
# Supply Supervisor Reset Pulse Generator

This block turns two digital fault indications into a clean system reset. One is a flag from an analog comparator that is high while the monitored supply sits above its trip point. The other is an active-low push-button or logic input that requests a reset. The block drives an active-low reset and its active-high complement. Both are registered and glitch-free.

Reset is held for as long as either fault is present. When the last fault clears, reset is stretched by a fixed hold time before it is released. Any new fault that arrives during that stretch clears the hold counter, so the full hold time is counted again from the end of the latest fault. The manual input only counts as a request when it stays low for a minimum number of clock cycles. Shorter dips are ignored.

Both inputs pass through a two-flop synchroniser. The hold time (`HOLD_CYC`) and the qualification time (`MR_QUAL_CYC`) are parameters given in clock cycles. With the defaults at 125 MHz they are 200 ms and just over 150 ns. The module reset `rst_n` is asynchronous on assertion and is expected to be released in step with `clk`.

Top module: `supv_reset_gen`

## Requirements
- R1: While `rst_n` is low, `reset_n_o` is 0 and `reset_o` is 1.
- R2: `reset_n_o` goes to 0 on the third rising edge of `clk` after `supply_ok_i` falls, and stays 0 for as long as `supply_ok_i` is low.
- R3: After `supply_ok_i` rises, with no other fault present, `reset_n_o` goes to 1 on the (`HOLD_CYC`+2)-th rising edge and not earlier.
- R4: A fault that arrives during the hold stretch keeps reset asserted and clears the hold counter. The release then comes `HOLD_CYC`+2 edges after `supply_ok_i` rises again, counted from that later rise.
- R5: A low pulse on `mr_n_i` that lasts fewer than `MR_QUAL_CYC` clock cycles has no effect on `reset_n_o`.
- R6: When `mr_n_i` is held low for at least `MR_QUAL_CYC` cycles, `reset_n_o` goes to 0 on the (`MR_QUAL_CYC`+3)-th rising edge after the fall.
- R7: After a qualified manual request, `reset_n_o` goes to 1 on the (`HOLD_CYC`+3)-th rising edge after `mr_n_i` returns high, provided the supply is good.
- R8: `reset_o` is always the exact complement of `reset_n_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| supply_ok_i | input | 1 | Comparator result, 1 = supply above trip point |
| mr_n_i | input | 1 | Manual reset request, active low, asynchronous |
| reset_n_o | output | 1 | System reset, active low |
| reset_o | output | 1 | System reset, active high |

## Verification
The hardest situation to reach is a fault arriving partway through a hold stretch that is already running. It can be a supply dip or a manual pulse right at the qualification boundary. In either case the result depends on exactly which counter value gets cleared. Directed cases place a brownout mid-stretch and manual pulses of exactly `MR_QUAL_CYC`-1 and `MR_QUAL_CYC` cycles, then measure release edges. A random phase then overlaps short supply dips and manual pulses of lengths near the threshold with hold windows, and compares every cycle against a bench model.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // Synchronised view of the two fault inputs
  typedef struct packed {
    logic supply_ok;
    logic mr_n;
  } supv_in_t;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/supv_sync.sv
module supv_sync
  import supv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  supv_in_t raw_i,
  output supv_in_t sync_o
);
  localparam int unsigned W = $bits(supv_in_t);
  // reset value: supply bad, manual input idle
  localparam supv_in_t RST_VAL = '{supply_ok: 1'b0, mr_n: 1'b1};

  logic [W-1:0] stage_q [SYNC_STAGES];

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
      logic [W-1:0] d;
      if (s == 0) begin : g_first
        assign d = raw_i;
      end else begin : g_next
        assign d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d;
      end
    end
  endgenerate

  assign sync_o = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/supv_mr_qual.sv
module supv_mr_qual #(
  parameter int unsigned QUAL_CYC = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n_s,
  output logic mr_active
);
  localparam int unsigned QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC);

  logic [QW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // count consecutive low samples, saturating at the threshold
  always_comb begin
    cnt_en = mr_n_s || (cnt_q != QMAX);
    if (mr_n_s) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign mr_active = (cnt_q == QMAX);

  a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= QMAX);
  a_r5_needs_low_input: assert property (@(posedge clk) disable iff (!rst_n)
    mr_active |-> !$past(mr_n_s));
  a_r7_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mr_n_s |=> cnt_q == '0);
endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer #(
  parameter int unsigned HOLD_CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  output logic release_q
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HMAX  = HW'(HOLD_CYC);
  localparam logic [HW-1:0] HLAST = HW'(HOLD_CYC - 1);

  logic [HW-1:0] hcnt_q, hcnt_d;
  logic          hcnt_en;
  logic          rel_d;

  always_comb begin
    hcnt_en = fault || (hcnt_q != HMAX);
    hcnt_d  = fault ? '0 : hcnt_q + 1'b1;
    rel_d   = !fault && (hcnt_q >= HLAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q    <= '0;
      release_q <= 1'b0;
    end else begin
      if (hcnt_en) hcnt_q <= hcnt_d;
      release_q <= rel_d;
    end
  end

  a_r2_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !release_q);
  a_r4_counter_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> hcnt_q == '0);
  a_r3_release_after_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    release_q |-> hcnt_q == HMAX);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt_q <= HMAX);
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int unsigned HOLD_CYC    = 25_000_000,
  parameter int unsigned MR_QUAL_CYC = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic mr_n_i,
  output logic reset_n_o,
  output logic reset_o
);
  supv_in_t raw, synced;
  logic     mr_active;
  logic     fault;
  logic     released;

  assign raw = '{supply_ok: supply_ok_i, mr_n: mr_n_i};

  supv_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw),
    .sync_o (synced)
  );

  supv_mr_qual #(.QUAL_CYC(MR_QUAL_CYC)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .mr_n_s    (synced.mr_n),
    .mr_active (mr_active)
  );

  assign fault = !synced.supply_ok || mr_active;

  supv_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault     (fault),
    .release_q (released)
  );

  assign reset_n_o = released;
  assign reset_o   = ~released;

  a_r2_supply_low_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    !synced.supply_ok |=> !reset_n_o);
  a_r6_manual_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    mr_active |=> reset_o);
  a_r8_complement: assert property (@(posedge clk) reset_o != reset_n_o);
endmodule

// File: tb/sim_supv_reset_gen.sv
module sim_supv_reset_gen;
  localparam int unsigned HOLD = 40;
  localparam int unsigned QUAL = 5;

  logic clk = 1'b0;
  logic rst_n, sup, mr_n;
  logic reset_n_o, reset_o;
  int   n_chk = 0, n_bad = 0;
  int   cyc = 0;
  string tag = "R2";

  always #4 clk = ~clk;  // 125 MHz

  supv_reset_gen #(.HOLD_CYC(HOLD), .MR_QUAL_CYC(QUAL)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(sup), .mr_n_i(mr_n),
    .reset_n_o(reset_n_o), .reset_o(reset_o)
  );

  // requirement-level model: 2-cycle input delay, low-run qualifier, hold stretch
  logic m_s1, m_s2, m_m1, m_m2, m_out;
  int   m_low, m_run;
  function automatic logic model_fault(logic s2, int low);
    return !s2 || (low >= QUAL);
  endfunction
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_m1 <= 1; m_m2 <= 1;
      m_low <= 0; m_run <= 0; m_out <= 0;
    end else begin
      m_s1 <= sup;  m_s2 <= m_s1;
      m_m1 <= mr_n; m_m2 <= m_m1;
      m_low <= m_m2 ? 0 : (m_low >= QUAL ? QUAL : m_low + 1);
      if (model_fault(m_s2, m_low)) begin
        m_run <= 0; m_out <= 0;
      end else begin
        m_run <= (m_run >= HOLD) ? HOLD : m_run + 1;
        m_out <= (m_run + 1 >= HOLD);
      end
    end
  end

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model and complement check (R8)
  always @(negedge clk) begin
    cyc++;
    if (rst_n === 1'b1) begin
      check(tag, reset_n_o, m_out);
      check("R8", reset_o, ~reset_n_o);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // count rising edges until reset_n_o equals val (sampled at negedge)
  task automatic edges_until(logic val, int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (reset_n_o !== val && n < lim);
  endtask

  int n;
  initial begin
    rst_n = 0; sup = 0; mr_n = 1;
    step(3);
    check("R1", reset_n_o, 1'b0);
    check("R1", reset_o, 1'b1);

    // R3: release after power-up
    rst_n = 1; sup = 1; tag = "R3";
    edges_until(1'b1, 4 * HOLD, n);
    check_int("R3", n, HOLD + 2);

    // R4: brownout during the hold stretch
    sup = 0; step(6); sup = 1; tag = "R4";
    step(HOLD / 2);
    sup = 0; step(4);
    check("R2", reset_n_o, 1'b0);
    sup = 1;
    edges_until(1'b1, 4 * HOLD, n);
    check_int("R4", n, HOLD + 2);

    // R5: short manual pulse ignored
    tag = "R5";
    mr_n = 0; step(QUAL - 1); mr_n = 1;
    step(QUAL + 10);
    check("R5", reset_n_o, 1'b1);

    // R6 / R7: qualified manual reset and its stretch
    tag = "R6";
    mr_n = 0;
    edges_until(1'b0, 4 * QUAL + 10, n);
    check_int("R6", n, QUAL + 3);
    step(3);
    mr_n = 1; tag = "R7";
    edges_until(1'b1, 4 * HOLD, n);
    check_int("R7", n, HOLD + 3);

    // random overlap of dips and manual pulses, compared each cycle
    tag = "R4";
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 300; k++) begin
      int sel = $urandom_range(0, 3);
      if (sel == 0) begin
        sup = 0; step($urandom_range(1, 6)); sup = 1;
      end else if (sel == 1) begin
        mr_n = 0; step($urandom_range(QUAL - 2, QUAL + 1)); mr_n = 1;
      end
      step($urandom_range(1, HOLD + 10));
    end
    sup = 1; mr_n = 1;
    step(HOLD + 5);
    check("R3", reset_n_o, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule